// File: doc/BRIEF.md
# PCM to PDM Delta-Sigma Transmitter

This block turns a stream of multi-bit PCM audio words into a one-bit pulse density stream for a digital speaker or codec. It holds each audio frame for a whole sample period (zero-order hold interpolation). Each PDM period, one second-order error-feedback modulator per channel turns the held value into one bit. A PDM clock runs at one quarter of the core clock. The data line carries the left bit in one half of each PDM clock period and the right bit in the other half, or a single channel for the whole period.

Words arrive on a valid/ready stream. A stereo frame takes two beats, left first and then right. A mono frame takes one beat. Oversampling ratio, channel mode, phase polarity and input width come from static inputs. They are captured when `en` rises and held for the whole run. A four-state fill machine collects frames. Its states are FILL_IDLE (disabled), FILL_WANT_A (waiting for the first word), FILL_WANT_B (waiting for the right word of a stereo frame) and FILL_FULL (frame buffered). Its transitions are:
- start: IDLE to WANT_A when the block is running.
- take-mono: WANT_A to FULL on a mono beat.
- take-left: WANT_A to WANT_B on a stereo beat.
- take-right: WANT_B to FULL on a beat.
- consume: FULL to WANT_A at a sample boundary.
- stop: any state to IDLE when the block is disabled.

Top module: `pdm_sigma_tx`

## Requirements
- R1: `pdm_clk` has a period of exactly 4 core cycles. It is high for 2 cycles, then low for 2. The modulator output changes only once per PDM period.
- R2: Oversampling code 0/1/2/3 gives 32/64/128/256 PDM periods per sample. In steady state with the source always valid, frames are taken exactly every 128 << code core cycles.
- R3: Channel code 0 is left only and code 1 is right only. Each takes one word per frame and drives its channel's bit for the whole PDM period. Code 2 is stereo and takes two words per frame, left then right. Code 3 behaves as stereo.
- R4: With polarity 0, the left bit is on the high half of `pdm_clk` and the right bit on the low half. Polarity 1 swaps the two halves.
- R5: Format 0 uses `in_data[15:0]` as a signed 16-bit sample scaled to full 24-bit range, and bits 23:16 have no effect. Format 1 uses all 24 bits as a signed sample.
- R6: A constant input x (24-bit signed, full scale FS = 2^23) gives, over 1024 PDM bits of its channel, a count of ones within 20 of 512 + 512·x/FS.
- R7: Full-scale positive or negative input saturates the modulator state instead of wrapping. The density of ones stays within 2% of 100% or 0%.
- R8: A sample boundary with no complete frame buffered keeps the previous sample in use. `underrun` is then high for exactly one core cycle. With the source always valid, `underrun` never rises.
- R9: While disabled, `in_ready` is low. `pdm_data` alternates 1, 0, 1, ... once per PDM period, and the modulator state is cleared.
- R10: The configuration resets to 64x, polarity 0, stereo and format 0. It is loaded from the inputs in the cycle `en` rises, and later changes while enabled have no effect.
- R11: During and right after reset, `in_ready` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, 4x the PDM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; rising edge captures configuration |
| osr_sel | input | 2 | Oversampling code, 0=32x .. 3=256x |
| chan_sel | input | 2 | 0 left, 1 right, 2/3 stereo |
| lr_swap | input | 1 | 0: left on high half of pdm_clk; 1: swapped |
| wide_fmt | input | 1 | 0: 16-bit samples in bits 15:0; 1: 24-bit samples |
| in_valid | input | 1 | Sample word valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | 24 | Signed sample word |
| pdm_clk | output | 1 | PDM clock, core clock divided by 4 |
| pdm_data | output | 1 | PDM data line |
| underrun | output | 1 | One-cycle pulse when a sample boundary finds no frame |

## Verification
Each sample boundary does two things at the same core clock edge. The fill machine must either hand a frame over or flag an underrun, and both modulators take their step. So when an underrun occurs, the held sample has to feed the step in that same cycle. The bench provokes this by stopping the source after a known stereo frame, then counting `underrun` pulses over 1024 PDM periods. In that same window it measures the density of both halves. It judges that one pulse per sample period appears, never two cycles wide, and that both densities still match the held left and right values.

// File: rtl/pdm_sigma_pkg.sv
package pdm_sigma_pkg;

    typedef enum logic [1:0] {
        OSR_X32  = 2'd0,
        OSR_X64  = 2'd1,
        OSR_X128 = 2'd2,
        OSR_X256 = 2'd3
    } osr_e;

    typedef enum logic [1:0] {
        CH_LEFT     = 2'd0,
        CH_RIGHT    = 2'd1,
        CH_BOTH     = 2'd2,
        CH_BOTH_ALT = 2'd3
    } chan_e;

    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_WANT_A,
        FILL_WANT_B,
        FILL_FULL
    } fill_e;

    typedef struct packed {
        osr_e  osr;
        chan_e chan;
        logic  swap;
        logic  wide;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{osr: OSR_X64, chan: CH_BOTH, swap: 1'b0, wide: 1'b0};

    function automatic logic is_stereo(chan_e c);
        return (c == CH_BOTH) || (c == CH_BOTH_ALT);
    endfunction

endpackage

// File: rtl/pdm_sigma_timer.sv
module pdm_sigma_timer #(
    parameter int BASE_OSR  = 32,
    parameter int CLK_DIV   = 4,
    parameter int OSR_CODES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic [1:0]                 osr_code,
    output logic [$clog2(CLK_DIV)-1:0] ph,
    output logic                       tick,
    output logic                       need,
    output logic                       hi_half
);
    localparam int PH_W    = $clog2(CLK_DIV);
    localparam int MAX_LEN = BASE_OSR << (OSR_CODES - 1);
    localparam int CNT_W   = $clog2(MAX_LEN);
    localparam int LEN_W   = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] len;

    assign len     = LEN_W'(BASE_OSR) << osr_code;
    assign tick    = (ph == PH_W'(CLK_DIV - 1));
    assign hi_half = (ph < PH_W'(CLK_DIV / 2));
    assign need    = run && tick && ({1'b0, cnt_q} == (len - LEN_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (tick) begin
            ph <= '0;
        end else begin
            ph <= ph + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            if ({1'b0, cnt_q} == (len - LEN_W'(1))) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_CLK_HIGH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_half) |=> hi_half); // R1
    AST_CLK_LOW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi_half) |=> !hi_half); // R1
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ({1'b0, cnt_q} < len)); // R2

endmodule

// File: rtl/pdm_sigma_fill.sv
module pdm_sigma_fill
    import pdm_sigma_pkg::*;
#(
    parameter int DW = 24,
    parameter int NW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  cfg_t                 cfg,
    input  logic                 need,
    input  logic                 in_valid,
    input  logic [DW-1:0]        in_data,
    output logic                 in_ready,
    output logic signed [DW-1:0] cur_l,
    output logic signed [DW-1:0] cur_r,
    output logic                 underrun
);
    fill_e         st_q;
    fill_e         st_d;
    logic          accept;
    logic          stereo;
    logic [DW-1:0] word;
    logic [DW-1:0] nxt_l;
    logic [DW-1:0] nxt_r;

    assign accept = in_valid && in_ready;
    assign stereo = is_stereo(cfg.chan);
    assign word   = cfg.wide ? in_data : {in_data[NW-1:0], {(DW - NW){1'b0}}};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= FILL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FILL_IDLE:   st_d = FILL_WANT_A;
            FILL_WANT_A: if (accept) st_d = stereo ? FILL_WANT_B : FILL_FULL;
            FILL_WANT_B: if (accept) st_d = FILL_FULL;
            FILL_FULL:   if (need)   st_d = FILL_WANT_A;
        endcase
        if (!run) begin
            st_d = FILL_IDLE;
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (st_q)
            FILL_WANT_A, FILL_WANT_B: in_ready = 1'b1;
            default:                  in_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_l    <= '0;
            nxt_r    <= '0;
            cur_l    <= '0;
            cur_r    <= '0;
            underrun <= 1'b0;
        end else if (!run) begin
            nxt_l    <= '0;
            nxt_r    <= '0;
            cur_l    <= '0;
            cur_r    <= '0;
            underrun <= 1'b0;
        end else begin
            if (accept) begin
                if (st_q == FILL_WANT_B || (st_q == FILL_WANT_A && cfg.chan == CH_RIGHT)) begin
                    nxt_r <= word;
                end else begin
                    nxt_l <= word;
                end
            end
            if (need && st_q == FILL_FULL) begin
                cur_l <= nxt_l;
                cur_r <= nxt_r;
            end
            underrun <= need && (st_q != FILL_FULL);
        end
    end

    AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun); // R8
    AST_HOLD_ON_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> ($stable(cur_l) && $stable(cur_r))); // R8
    AST_READY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> !in_ready); // R9

endmodule

// File: rtl/pdm_sigma_dsm.sv
module pdm_sigma_dsm #(
    parameter int DW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    input  logic signed [DW-1:0] x,
    output logic                 bit_o
);
    localparam int ST_W = DW + 5;
    localparam int AC_W = DW + 8;
    localparam logic signed [AC_W-1:0] FS_V  = AC_W'(longint'(1) << (DW - 1));
    localparam logic signed [AC_W-1:0] LIM_V = AC_W'(longint'(8) << (DW - 1));

    logic signed [ST_W-1:0] q1_q;
    logic signed [ST_W-1:0] q2_q;
    logic signed [AC_W-1:0] xe;
    logic signed [AC_W-1:0] q1e;
    logic signed [AC_W-1:0] q2e;
    logic signed [AC_W-1:0] u;
    logic signed [AC_W-1:0] us;
    logic signed [AC_W-1:0] y;
    logic signed [AC_W-1:0] qn;

    always_comb begin
        xe  = {{(AC_W - DW){x[DW-1]}}, x};
        q1e = {{(AC_W - ST_W){q1_q[ST_W-1]}}, q1_q};
        q2e = {{(AC_W - ST_W){q2_q[ST_W-1]}}, q2_q};
        u   = xe - (q1e <<< 1) + q2e;
        if (u > LIM_V) begin
            us = LIM_V;
        end else if (u < -LIM_V) begin
            us = -LIM_V;
        end else begin
            us = u;
        end
        y  = us[AC_W-1] ? -FS_V : FS_V;
        qn = y - us;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q1_q  <= '0;
            q2_q  <= '0;
            bit_o <= 1'b0;
        end else if (clr) begin
            q1_q  <= '0;
            q2_q  <= '0;
            bit_o <= 1'b0;
        end else if (step) begin
            q2_q  <= q1_q;
            q1_q  <= qn[ST_W-1:0];
            bit_o <= ~us[AC_W-1];
        end
    end

    AST_BIT_ONCE_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step) && !$past(clr)) |-> $stable(bit_o)); // R1

endmodule

// File: rtl/pdm_sigma_tx.sv
module pdm_sigma_tx
    import pdm_sigma_pkg::*;
#(
    parameter int DW       = 24,
    parameter int NW       = 16,
    parameter int BASE_OSR = 32,
    parameter int CLK_DIV  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    osr_sel,
    input  logic [1:0]    chan_sel,
    input  logic          lr_swap,
    input  logic          wide_fmt,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          pdm_clk,
    output logic          pdm_data,
    output logic          underrun
);
    localparam int PH_W = $clog2(CLK_DIV);
    localparam int N_CH = 2;

    logic                 en_q;
    logic                 run;
    cfg_t                 cfg_q;
    logic                 idle_q;
    logic [PH_W-1:0]      ph;
    logic                 tick;
    logic                 need;
    logic                 hi_half;
    logic signed [DW-1:0] cur_l;
    logic signed [DW-1:0] cur_r;
    logic [N_CH-1:0]      bits;
    logic                 first_bit;
    logic                 second_bit;

    assign run = en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            cfg_q  <= CFG_RESET;
            idle_q <= 1'b0;
        end else begin
            en_q <= en;
            if (en && !en_q) begin
                cfg_q <= '{osr: osr_e'(osr_sel), chan: chan_e'(chan_sel),
                           swap: lr_swap, wide: wide_fmt};
            end
            if (tick) begin
                idle_q <= ~idle_q;
            end
        end
    end

    pdm_sigma_timer #(
        .BASE_OSR (BASE_OSR),
        .CLK_DIV  (CLK_DIV),
        .OSR_CODES(4)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .osr_code(cfg_q.osr),
        .ph      (ph),
        .tick    (tick),
        .need    (need),
        .hi_half (hi_half)
    );

    pdm_sigma_fill #(
        .DW(DW),
        .NW(NW)
    ) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cfg     (cfg_q),
        .need    (need),
        .in_valid(in_valid),
        .in_data (in_data),
        .in_ready(in_ready),
        .cur_l   (cur_l),
        .cur_r   (cur_r),
        .underrun(underrun)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pdm_sigma_dsm #(
            .DW(DW)
        ) u_dsm (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (!run),
            .step (tick),
            .x    ((g == 0) ? cur_l : cur_r),
            .bit_o(bits[g])
        );
    end

    assign pdm_clk = hi_half;

    always_comb begin
        first_bit  = cfg_q.swap ? bits[1] : bits[0];
        second_bit = cfg_q.swap ? bits[0] : bits[1];
        if (!run) begin
            pdm_data = idle_q;
        end else if (is_stereo(cfg_q.chan)) begin
            pdm_data = hi_half ? first_bit : second_bit;
        end else if (cfg_q.chan == CH_RIGHT) begin
            pdm_data = bits[1];
        end else begin
            pdm_data = bits[0];
        end
    end

    AST_HALF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (ph == PH_W'(1) || ph == PH_W'(3))) |-> $stable(pdm_data)); // R4
    AST_IDLE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && !en_q && !$past(en_q)) |-> (pdm_data != $past(pdm_data))); // R9
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> $stable(cfg_q)); // R10

endmodule

// File: tb/tb_pdm_sigma_tx.sv
module tb_pdm_sigma_tx;
    localparam int N_VEC = 6;
    localparam int TOL   = 20;

    // {osr[53:52], chan[51:50], swap[49], wide[48], left[47:24], right[23:0]}
    localparam logic [53:0] VEC [N_VEC] = '{
        {2'd1, 2'd2, 1'b0, 1'b0, 24'hAB2000, 24'h55C000},
        {2'd0, 2'd2, 1'b1, 1'b1, 24'h200000, 24'hC00000},
        {2'd2, 2'd0, 1'b0, 1'b0, 24'h004000, 24'h7F0000},
        {2'd3, 2'd1, 1'b1, 1'b1, 24'h123456, 24'hE00000},
        {2'd0, 2'd2, 1'b0, 1'b1, 24'h7FFFFF, 24'h800000},
        {2'd0, 2'd3, 1'b0, 1'b0, 24'h000000, 24'h001000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  osr_sel = 2'd0;
    logic [1:0]  chan_sel = 2'd0;
    logic        lr_swap = 1'b0;
    logic        wide_fmt = 1'b0;
    logic        src_on = 1'b0;
    logic        in_valid;
    logic        in_ready;
    logic [23:0] in_data;
    logic        pdm_clk;
    logic        pdm_data;
    logic        underrun;

    logic [53:0] cur_vec = '0;
    logic        beat = 1'b0;
    int          cyc = 0;
    int          hs_last = 0;
    int          hs_prev = 0;
    int          ur_cnt = 0;
    int          ur_dbl = 0;
    logic        ur_prev = 1'b0;
    int          n_chk = 0;
    int          n_err = 0;

    always #10 clk = ~clk;

    function automatic logic [23:0] pick_word(logic [53:0] v, logic b);
        if (v[51:50] == 2'd1) return v[23:0];
        if (v[51:50] == 2'd0) return v[47:24];
        return b ? v[23:0] : v[47:24];
    endfunction

    assign in_valid = src_on;
    assign in_data  = pick_word(cur_vec, beat);

    pdm_sigma_tx dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .osr_sel (osr_sel),
        .chan_sel(chan_sel),
        .lr_swap (lr_swap),
        .wide_fmt(wide_fmt),
        .in_valid(in_valid),
        .in_ready(in_ready),
        .in_data (in_data),
        .pdm_clk (pdm_clk),
        .pdm_data(pdm_data),
        .underrun(underrun)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // stream source: one beat per handshake, left then right in stereo
    initial forever begin
        @(negedge clk);
        if (!en) begin
            beat = 1'b0;
        end else if (in_valid && in_ready) begin
            if (cur_vec[51:50] < 2'd2 || !beat) begin
                hs_prev = hs_last;
                hs_last = cyc + 1;
            end
            @(posedge clk);
            #1;
            if (cur_vec[51:50] >= 2'd2) beat = ~beat;
        end
    end

    initial forever begin
        @(negedge clk);
        if (underrun) ur_cnt++;
        if (underrun && ur_prev) ur_dbl++;
        ur_prev = underrun;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    function automatic int exp_cnt(logic [23:0] v, logic wide);
        logic signed [23:0] s;
        s = wide ? v : {v[15:0], 8'h00};
        return 512 + int'(s >>> 14);
    endfunction

    task automatic align_high();
        logic p;
        do begin
            p = pdm_clk;
            @(negedge clk);
        end while (!(pdm_clk && !p));
    endtask

    task automatic measure(output int ca, output int cb);
        ca = 0;
        cb = 0;
        align_high();
        for (int i = 0; i < 1024; i++) begin
            ca += int'(pdm_data);
            repeat (2) @(negedge clk);
            cb += int'(pdm_data);
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic start_run(input logic [53:0] v);
        en = 1'b0;
        src_on = 1'b0;
        repeat (8) @(negedge clk);
        cur_vec  = v;
        osr_sel  = v[53:52];
        chan_sel = v[51:50];
        lr_swap  = v[49];
        wide_fmt = v[48];
        src_on   = 1'b1;
        en       = 1'b1;
        repeat (3 * (128 << v[53:52]) + 16) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 200000);
        summary();
        $finish;
    end

    initial begin
        int ca;
        int cb;
        int ea;
        int eb;
        int ur0;
        logic [53:0] v;
        logic last;

        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R11 ready in reset", int'(in_ready), 0);
        chk(underrun == 1'b0, "R11 underrun in reset", int'(underrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0 && underrun == 1'b0, "R11 after reset",
            int'({in_ready, underrun}), 0);

        // R1: clock shape
        align_high();
        for (int i = 0; i < 8; i++) begin
            chk(pdm_clk == ((i % 4) < 2), "R1 pdm_clk pattern", int'(pdm_clk), int'((i % 4) < 2));
            @(negedge clk);
        end

        // R9: idle pattern after reset
        align_high();
        last = pdm_data;
        for (int i = 0; i < 6; i++) begin
            repeat (4) @(negedge clk);
            chk(pdm_data != last, "R9 idle alternation", int'(pdm_data), int'(!last));
            last = pdm_data;
        end

        // table of vectors
        for (int k = 0; k < N_VEC; k++) begin
            v = VEC[k];
            start_run(v);
            chk((hs_last - hs_prev) == (128 << v[53:52]), "R2 R3 frame interval",
                hs_last - hs_prev, 128 << v[53:52]);
            if (v[51:50] >= 2'd2) begin
                ea = v[49] ? exp_cnt(v[23:0], v[48]) : exp_cnt(v[47:24], v[48]);
                eb = v[49] ? exp_cnt(v[47:24], v[48]) : exp_cnt(v[23:0], v[48]);
            end else begin
                ea = (v[51:50] == 2'd1) ? exp_cnt(v[23:0], v[48]) : exp_cnt(v[47:24], v[48]);
                eb = ea;
            end
            ur0 = ur_cnt;
            measure(ca, cb);
            chk(ca >= ea - TOL && ca <= ea + TOL, "R6 R4 R5 R7 first-half density", ca, ea);
            chk(cb >= eb - TOL && cb <= eb + TOL, "R6 R3 R4 R7 second-half density", cb, eb);
            chk(ur_cnt == ur0, "R8 no underrun with live source", ur_cnt - ur0, 0);
        end

        // R10: configuration changes while enabled are ignored
        start_run(VEC[1]);
        osr_sel  = 2'd3;
        chan_sel = 2'd0;
        lr_swap  = 1'b0;
        repeat (3 * 128) @(negedge clk);
        chk((hs_last - hs_prev) == 128, "R10 osr held while enabled", hs_last - hs_prev, 128);
        measure(ca, cb);
        chk(ca >= 256 - TOL && ca <= 256 + TOL, "R10 polarity held", ca, 256);

        // R8: underrun with held sample
        start_run(VEC[0]);
        src_on = 1'b0;
        repeat (2 * 256 * 4) @(negedge clk);
        ur0 = ur_cnt;
        ur_dbl = 0;
        measure(ca, cb);
        chk((ur_cnt - ur0) >= 15 && (ur_cnt - ur0) <= 17, "R8 underrun per boundary",
            ur_cnt - ur0, 16);
        chk(ur_dbl == 0, "R8 underrun one cycle wide", ur_dbl, 0);
        chk(ca >= 640 - TOL && ca <= 640 + TOL, "R8 left held", ca, 640);
        chk(cb >= 256 - TOL && cb <= 256 + TOL, "R8 right held", cb, 256);

        // R9: disable
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk(in_ready == 1'b0, "R9 ready low when disabled", int'(in_ready), 0);
        align_high();
        last = pdm_data;
        for (int i = 0; i < 6; i++) begin
            repeat (4) @(negedge clk);
            chk(pdm_data != last, "R9 idle alternation after run", int'(pdm_data), int'(!last));
            last = pdm_data;
        end

        summary();
        $finish;
    end

endmodule